// File: doc/BRIEF.md
# Reload Event Timer

This block is a 16-bit down-counting timer that reloads from a programmable reload register each time it passes zero. Every underflow toggles a pulse output and raises a one-cycle interrupt. The count tick comes from one of several sources. Three are strobes taken from a free-running prescaler (every clock, every 2nd clock, every 8th clock). Two are enable inputs for a low-speed clock and a subsystem clock. The last is an external event pin, so the whole block runs in one clock domain.

The event pin first passes through a two-flop synchronizer. It then goes through an optional majority-free noise filter. In that filter a new level is accepted only after three consecutive samples disagree with the level currently held. The samples are taken every clock, every 8th clock or every 32nd clock. After the filter comes edge selection, which counts rising edges, falling edges or both. A gate can also be enabled. The gate comes from an external pin or from an internal timer output, and events count only while the chosen gate signal sits at a programmed level.

Control is a small state machine with two states. In ST_IDLE the counter holds. The transition ST_IDLE to ST_RUN occurs on a start pulse when stop is low. In ST_RUN the counter moves on every selected tick. The transition ST_RUN (or ST_IDLE) to ST_IDLE occurs on a stop pulse, and this also reloads the counter and clears the pulse output. The filter is a second two-state machine with states LVL_LO and LVL_HI. Its transitions LVL_LO to LVL_HI and LVL_HI to LVL_LO each fire on the third consecutive disagreeing sample.

Top module: `reload_event_timer`

## Requirements
- R1: After reset the counter and the reload register both read 0xFFFF, the pulse output and interrupt are low, and the mode register is 0, which selects the system clock as the tick source.
- R2: The write port with `wr_sel`=0 loads the mode register from `wr_data[9:0]` in this layout:
  - bits [2:0] select the tick source: 0 every clock, 1 every 2nd clock, 2 every 8th clock, 3 `low_tick`, 4 `sub_tick`, 5 the conditioned event; 6 and 7 give no tick.
  - bits [4:3] select the filter.
  - bit 5 selects double edge.
  - bit 6 selects falling edge.
  - bit 7 enables the gate.
  - bit 8 selects the internal gate.
  - bit 9 sets the gate level.

  With reload N, interrupts then recur every (N+1) source ticks.
- R3: While running, the counter drops by one on each tick. On a tick at zero it takes the reload register value instead. With no tick it holds.
- R4: Each underflow raises `irq` for exactly one clock, in the cycle after the tick edge, together with the reloaded count.
- R5: `pulse_out` changes level on every underflow.
- R6: A stop pulse moves the block to ST_IDLE, sets the counter to the reload value and drives `pulse_out` low. In ST_IDLE neither ticks nor events change the count. Stop takes priority over a simultaneous start.
- R7: A write with `wr_sel`=1 sets the reload register. In ST_IDLE it also loads the counter at once. In ST_RUN the count is untouched and the new value is first used at the next underflow.
- R8: With bit 5 clear, bit 6 = 0 counts rising event edges and bit 6 = 1 counts falling ones. With bit 5 set, both edges count.
- R9: Filter code 0 passes the synchronized pin straight through, so a 2-cycle pulse counts. Code 1 samples every clock and needs 3 agreeing samples, so a 2-cycle pulse is rejected and a 10-cycle pulse counts.
- R10: Filter code 3 samples every 32nd clock, so a 40-cycle pulse is rejected and a 200-cycle pulse counts. Code 2 samples every 8th clock.
- R11: With bit 7 set, events count only while the gate chosen by bit 8 (0 `gate_ext`, 1 `gate_int`) equals bit 9. With bit 7 clear, the gate has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 mode register, 1 reload register |
| wr_data | input | 16 | Write data |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse, returns to initial state |
| low_tick | input | 1 | Low-speed clock enable strobe |
| sub_tick | input | 1 | Subsystem clock enable strobe |
| evt_in | input | 1 | External event pin |
| gate_ext | input | 1 | External gate pin |
| gate_int | input | 1 | Internal gate from another timer |
| count_out | output | 16 | Current counter value |
| pulse_out | output | 1 | Underflow toggle output |
| irq | output | 1 | One-cycle underflow interrupt |

## Verification
The bench uses the default parameters: a 16-bit counter, a two-stage synchronizer, a three-sample filter, and prescaler taps at 2, 8 and 32. With these, every source rate is reachable within a few dozen cycles per underflow when small reload values are used. The 32-clock filter rate makes the rejection window about 64 cycles. That window is short enough for both a rejected 40-cycle glitch and an accepted 200-cycle pulse to fit in one run. The bench drives the low-speed and subsystem strobes every 5th and 3rd cycle, so those sources give distinct underflow periods.

// File: rtl/ret_pkg.sv
package ret_pkg;

    localparam int MODE_W = 10;

    localparam logic [2:0] SRC_CLK  = 3'd0;
    localparam logic [2:0] SRC_DIV2 = 3'd1;
    localparam logic [2:0] SRC_DIV8 = 3'd2;
    localparam logic [2:0] SRC_LOW  = 3'd3;
    localparam logic [2:0] SRC_SUB  = 3'd4;
    localparam logic [2:0] SRC_EVT  = 3'd5;

    localparam logic [1:0] FLT_BYPASS = 2'd0;
    localparam logic [1:0] FLT_CLK    = 2'd1;
    localparam logic [1:0] FLT_DIV8   = 2'd2;
    localparam logic [1:0] FLT_DIV32  = 2'd3;

    typedef struct packed {
        logic       gate_lvl;
        logic       gate_int_sel;
        logic       gate_en;
        logic       edge_fall;
        logic       edge_both;
        logic [1:0] flt_sel;
        logic [2:0] src_sel;
    } mode_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } run_state_e;

    typedef enum logic {
        LVL_LO,
        LVL_HI
    } flt_state_e;

endpackage

// File: rtl/ret_sync.sv
module ret_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ret_prescaler.sv
module ret_prescaler #(
    parameter int TAP_A_LOG = 1,
    parameter int TAP_B_LOG = 3,
    parameter int TAP_C_LOG = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb_a_o,
    output logic stb_b_o,
    output logic stb_c_o
);
    localparam int PRE_W = TAP_C_LOG;

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign stb_a_o = &pre_q[TAP_A_LOG-1:0];
    assign stb_b_o = &pre_q[TAP_B_LOG-1:0];
    assign stb_c_o = &pre_q[TAP_C_LOG-1:0];

    // R2
    strobe_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_c_o |-> stb_b_o) and (stb_b_o |-> stb_a_o))
        else $error("slow strobe without faster strobe");

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_a_o |=> !stb_a_o)
        else $error("divide-by-2 strobe on two cycles in a row");
endmodule

// File: rtl/ret_event_cond.sv
module ret_event_cond
    import ret_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FLT_DEPTH   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_i,
    input  logic       gate_ext_i,
    input  logic       gate_int_i,
    input  logic [1:0] flt_sel_i,
    input  logic       edge_both_i,
    input  logic       edge_fall_i,
    input  logic       gate_en_i,
    input  logic       gate_int_sel_i,
    input  logic       gate_lvl_i,
    input  logic       stb_b_i,
    input  logic       stb_c_i,
    output logic       ev_tick_o
);
    localparam int             AGREE_W    = $clog2(FLT_DEPTH);
    localparam logic [AGREE_W-1:0] AGREE_LAST = AGREE_W'(FLT_DEPTH - 1);

    logic [2:0]         sync_s;
    logic               evt_s;
    logic               gext_s;
    logic               gint_s;
    logic               smp;
    logic               differs;
    flt_state_e         lvl_q;
    flt_state_e         lvl_nxt;
    logic [AGREE_W-1:0] agree_q;
    logic [AGREE_W-1:0] agree_nxt;
    logic               filt;
    logic               filt_d_q;
    logic               rise;
    logic               fall;
    logic               edge_hit;
    logic               gate_raw;
    logic               gate_open;

    ret_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({gate_int_i, gate_ext_i, evt_i}),
        .q_o   (sync_s)
    );

    assign evt_s  = sync_s[0];
    assign gext_s = sync_s[1];
    assign gint_s = sync_s[2];

    always_comb begin
        unique case (flt_sel_i)
            FLT_BYPASS: smp = 1'b0;
            FLT_CLK:    smp = 1'b1;
            FLT_DIV8:   smp = stb_b_i;
            FLT_DIV32:  smp = stb_c_i;
            default:    smp = 1'b0;
        endcase
    end

    // filter level state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= LVL_LO;
            agree_q <= '0;
        end else begin
            lvl_q   <= lvl_nxt;
            agree_q <= agree_nxt;
        end
    end

    // filter next state
    always_comb begin
        lvl_nxt   = lvl_q;
        agree_nxt = agree_q;
        unique case (lvl_q)
            LVL_LO:  differs = evt_s;
            LVL_HI:  differs = !evt_s;
            default: differs = 1'b0;
        endcase
        if (smp) begin
            if (differs) begin
                if (agree_q == AGREE_LAST) begin
                    lvl_nxt   = (lvl_q == LVL_LO) ? LVL_HI : LVL_LO;
                    agree_nxt = '0;
                end else begin
                    agree_nxt = agree_q + 1'b1;
                end
            end else begin
                agree_nxt = '0;
            end
        end
    end

    assign filt = (flt_sel_i == FLT_BYPASS) ? evt_s : (lvl_q == LVL_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_d_q <= 1'b0;
        end else begin
            filt_d_q <= filt;
        end
    end

    assign rise     = filt & ~filt_d_q;
    assign fall     = ~filt & filt_d_q;
    assign edge_hit = edge_both_i ? (rise | fall) : (edge_fall_i ? fall : rise);

    assign gate_raw  = gate_int_sel_i ? gint_s : gext_s;
    assign gate_open = !gate_en_i || (gate_raw == gate_lvl_i);
    assign ev_tick_o = edge_hit & gate_open;

    // R10
    flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp |=> $stable(lvl_q))
        else $error("filter level moved without a sample strobe");

    // R9
    flt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> ($past(agree_q) == AGREE_LAST))
        else $error("filter level moved before enough agreeing samples");

    // R8
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tick_o && !edge_both_i && !edge_fall_i) |-> (filt && !filt_d_q))
        else $error("rising-edge mode produced an event without a rise");
endmodule

// File: rtl/ret_core.sv
module ret_core
    import ret_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             ld_en_i,
    input  logic [CNT_W-1:0] ld_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pulse_o,
    output logic             irq_o
);
    run_state_e       state_q;
    run_state_e       state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;
    logic             irq_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (!stop_i && start_i) state_nxt = ST_RUN;
            ST_RUN:  if (stop_i)             state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // counter and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '1;
            pulse_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (stop_i) begin
                cnt_q   <= reload_i;
                pulse_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (ld_en_i) cnt_q <= ld_val_i;
                    end
                    ST_RUN: begin
                        if (tick_i) begin
                            if (cnt_q == '0) begin
                                cnt_q   <= reload_i;
                                pulse_q <= ~pulse_q;
                                irq_q   <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q - 1'b1;
                            end
                        end
                    end
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign pulse_o = pulse_q;
    assign irq_o   = irq_q;

    // R6
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !irq_q)
        else $error("interrupt while idle");

    // R6
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_q == ST_IDLE && !pulse_q))
        else $error("stop did not return to idle");

    // R3
    uflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cnt_q == $past(reload_i)))
        else $error("underflow did not load the reload value");

    // R5
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (pulse_q != $past(pulse_q)))
        else $error("pulse output did not toggle on underflow");

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !tick_i && !stop_i) |=> $stable(cnt_q))
        else $error("counter moved without a tick");

    // R3
    dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick_i && !stop_i && cnt_q != '0)
            |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("counter did not decrement on tick");
endmodule

// File: rtl/reload_event_timer.sv
module reload_event_timer
    import ret_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FLT_DEPTH   = 3,
    parameter int TAP_A_LOG   = 1,
    parameter int TAP_B_LOG   = 3,
    parameter int TAP_C_LOG   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             start,
    input  logic             stop,
    input  logic             low_tick,
    input  logic             sub_tick,
    input  logic             evt_in,
    input  logic             gate_ext,
    input  logic             gate_int,
    output logic [CNT_W-1:0] count_out,
    output logic             pulse_out,
    output logic             irq
);
    mode_t            mode_q;
    logic [CNT_W-1:0] reload_q;
    logic             stb_a;
    logic             stb_b;
    logic             stb_c;
    logic             ev_tick;
    logic             tick;
    logic             ld_en;

    assign ld_en = wr_en && wr_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            reload_q <= '1;
        end else if (wr_en) begin
            if (wr_sel) reload_q <= wr_data;
            else        mode_q   <= mode_t'(wr_data[MODE_W-1:0]);
        end
    end

    ret_prescaler #(
        .TAP_A_LOG (TAP_A_LOG),
        .TAP_B_LOG (TAP_B_LOG),
        .TAP_C_LOG (TAP_C_LOG)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_a_o (stb_a),
        .stb_b_o (stb_b),
        .stb_c_o (stb_c)
    );

    ret_event_cond #(
        .SYNC_STAGES (SYNC_STAGES),
        .FLT_DEPTH   (FLT_DEPTH)
    ) u_evt (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_i          (evt_in),
        .gate_ext_i     (gate_ext),
        .gate_int_i     (gate_int),
        .flt_sel_i      (mode_q.flt_sel),
        .edge_both_i    (mode_q.edge_both),
        .edge_fall_i    (mode_q.edge_fall),
        .gate_en_i      (mode_q.gate_en),
        .gate_int_sel_i (mode_q.gate_int_sel),
        .gate_lvl_i     (mode_q.gate_lvl),
        .stb_b_i        (stb_b),
        .stb_c_i        (stb_c),
        .ev_tick_o      (ev_tick)
    );

    always_comb begin
        unique case (mode_q.src_sel)
            SRC_CLK:  tick = 1'b1;
            SRC_DIV2: tick = stb_a;
            SRC_DIV8: tick = stb_b;
            SRC_LOW:  tick = low_tick;
            SRC_SUB:  tick = sub_tick;
            SRC_EVT:  tick = ev_tick;
            default:  tick = 1'b0;
        endcase
    end

    ret_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .start_i  (start),
        .stop_i   (stop),
        .reload_i (reload_q),
        .ld_en_i  (ld_en),
        .ld_val_i (wr_data),
        .cnt_o    (count_out),
        .pulse_o  (pulse_out),
        .irq_o    (irq)
    );

    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && reload_q != '0 && $past(reload_q) != '0 && !$past(wr_en)) |=> !irq)
        else $error("interrupt wider than one cycle with nonzero reload");
endmodule

// File: tb/tb_reload_event_timer.sv
module tb_reload_event_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        low_tick = 1'b0;
    logic        sub_tick = 1'b0;
    logic        evt_in = 1'b0;
    logic        gate_ext = 1'b0;
    logic        gate_int = 1'b0;
    logic [15:0] count_out;
    logic        pulse_out;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int lt_cnt = 0;
    int st_cnt = 0;

    always #5 clk = ~clk;

    reload_event_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .start     (start),
        .stop      (stop),
        .low_tick  (low_tick),
        .sub_tick  (sub_tick),
        .evt_in    (evt_in),
        .gate_ext  (gate_ext),
        .gate_int  (gate_int),
        .count_out (count_out),
        .pulse_out (pulse_out),
        .irq       (irq)
    );

    // low-speed strobe every 5th cycle, subsystem strobe every 3rd cycle
    always @(negedge clk) begin
        low_tick = (lt_cnt == 4);
        lt_cnt   = (lt_cnt == 4) ? 0 : lt_cnt + 1;
        sub_tick = (st_cnt == 2);
        st_cnt   = (st_cnt == 2) ? 0 : st_cnt + 1;
    end

    typedef struct packed {
        logic [2:0]  src;
        logic [15:0] rl;
        logic [15:0] per;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 16'd3, 16'd4},
        '{3'd0, 16'd0, 16'd1},
        '{3'd1, 16'd4, 16'd10},
        '{3'd2, 16'd2, 16'd24},
        '{3'd3, 16'd3, 16'd20},
        '{3'd4, 16'd5, 16'd18}
    };

    function automatic logic [15:0] mk_mode(logic [2:0] s, logic [1:0] f, logic d,
                                            logic p, logic ge, logic gs, logic gl);
        return {6'b0, gl, gs, ge, p, d, f, s};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic sel, logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1; cyc(1); start = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1; cyc(1); stop = 1'b0;
    endtask

    task automatic ev_pulse(int hi, int lo);
        evt_in = 1'b1; cyc(hi);
        evt_in = 1'b0; cyc(lo);
    endtask

    task automatic setup(logic [15:0] mode, logic [15:0] rl);
        do_stop();
        wr(1'b0, mode);
        wr(1'b1, rl);
        do_start();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic p0;
        int   k;
        int   m;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 count", 32'(count_out), 32'hFFFF);
        chk("R1 pulse", 32'(pulse_out), 32'd0);
        chk("R1 irq",   32'(irq),       32'd0);
        do_start();
        cyc(2);
        chk("R1 default reload and clock source", 32'(count_out), 32'hFFFD);

        // R2 / R5 table walk: underflow period per source
        for (int i = 0; i < 6; i++) begin
            setup(mk_mode(VECS[i].src, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), VECS[i].rl);
            k = 0;
            while (!irq && k < 3000) begin cyc(1); k++; end
            p0 = pulse_out;
            m = 0;
            do begin cyc(1); m++; end while (!irq && m < 3000);
            chk("R2 period", 32'(m), 32'(VECS[i].per));
            chk("R5 toggle", 32'(pulse_out), 32'(!p0));
        end

        // R7 idle write loads counter
        do_stop();
        wr(1'b0, mk_mode(3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        wr(1'b1, 16'd10);
        chk("R7 idle load", 32'(count_out), 32'd10);
        do_start();
        chk("R3 no move on start edge", 32'(count_out), 32'd10);
        cyc(4);
        chk("R3 countdown", 32'(count_out), 32'd6);
        wr(1'b1, 16'd2);
        chk("R7 running write no load", 32'(count_out), 32'd5);
        cyc(5);
        chk("R3 reaches zero", 32'(count_out), 32'd0);
        cyc(1);
        chk("R7 new reload used at underflow", 32'(count_out), 32'd2);
        chk("R4 irq high", 32'(irq), 32'd1);
        chk("R5 pulse high", 32'(pulse_out), 32'd1);
        cyc(1);
        chk("R4 irq one cycle", 32'(irq), 32'd0);
        chk("R3 continues", 32'(count_out), 32'd1);

        // R6 stop
        do_stop();
        chk("R6 stop reloads", 32'(count_out), 32'd2);
        chk("R6 stop clears pulse", 32'(pulse_out), 32'd0);
        cyc(5);
        chk("R6 halted", 32'(count_out), 32'd2);
        start = 1'b1; stop = 1'b1; cyc(1); start = 1'b0; stop = 1'b0;
        cyc(3);
        chk("R6 stop wins", 32'(count_out), 32'd2);

        // R6 events ignored while idle
        wr(1'b0, mk_mode(3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        ev_pulse(20, 20);
        chk("R6 idle ignores events", 32'(count_out), 32'd2);

        // R8 rising
        setup(mk_mode(3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16'd20);
        ev_pulse(20, 20); ev_pulse(20, 20); ev_pulse(20, 20);
        cyc(10);
        chk("R8 rising count", 32'(count_out), 32'd17);

        // R8 falling
        setup(mk_mode(3'd5, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), 16'd20);
        evt_in = 1'b1; cyc(20);
        chk("R8 falling ignores rise", 32'(count_out), 32'd20);
        evt_in = 1'b0; cyc(20);
        chk("R8 falling counts fall", 32'(count_out), 32'd19);

        // R8 double
        setup(mk_mode(3'd5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0), 16'd20);
        ev_pulse(20, 20); ev_pulse(20, 20);
        chk("R8 double edge", 32'(count_out), 32'd16);

        // R9 bypass vs clock-rate filter
        setup(mk_mode(3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16'd20);
        ev_pulse(2, 20);
        chk("R9 bypass passes glitch", 32'(count_out), 32'd19);
        setup(mk_mode(3'd5, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16'd20);
        ev_pulse(2, 20);
        chk("R9 filter rejects glitch", 32'(count_out), 32'd20);
        ev_pulse(10, 20);
        chk("R9 filter passes pulse", 32'(count_out), 32'd19);

        // R10 slow filter
        setup(mk_mode(3'd5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16'd20);
        ev_pulse(40, 150);
        chk("R10 slow filter rejects 40", 32'(count_out), 32'd20);
        ev_pulse(200, 200);
        chk("R10 slow filter passes 200", 32'(count_out), 32'd19);

        // R11 external gate, active high
        gate_ext = 1'b0; gate_int = 1'b1;
        setup(mk_mode(3'd5, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1), 16'd20);
        cyc(5);
        ev_pulse(20, 20); ev_pulse(20, 20);
        chk("R11 ext gate closed", 32'(count_out), 32'd20);
        gate_ext = 1'b1; cyc(10);
        ev_pulse(20, 20); ev_pulse(20, 20);
        chk("R11 ext gate open", 32'(count_out), 32'd18);

        // R11 internal gate, active low
        gate_int = 1'b1; gate_ext = 1'b0;
        setup(mk_mode(3'd5, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0), 16'd20);
        cyc(5);
        ev_pulse(20, 20); ev_pulse(20, 20);
        chk("R11 int gate closed", 32'(count_out), 32'd20);
        gate_int = 1'b0; gate_ext = 1'b1; cyc(10);
        ev_pulse(20, 20); ev_pulse(20, 20);
        chk("R11 int gate open", 32'(count_out), 32'd18);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule